// File: doc/BRIEF.md
# Configurable Logic Cell Row

This block models a row of programmable logic cells. Each cell's configuration word picks one of two modes. In general-logic mode, a 16-bit truth table is indexed by four data inputs, so the cell computes any Boolean function of those inputs. In arithmetic mode, the same table is split into two halves. Each half is a 3-input table indexed by two data inputs and the incoming carry. One half gives a sum bit and the other gives a carry bit, and the carry travels to the next cell over a dedicated chain. A row of cells set up as full adders therefore forms a ripple adder, a counter or a comparator.

Every cell has one flip-flop. The flip-flop normally captures the table result. When the cell is set to do so, it captures the flip-flop of the cell below it instead, which turns the row into a shift register. Three controls shared by the whole row act on all flip-flops: an asynchronous clear, a synchronous clear and a synchronous load. A per-cell bit chooses whether the two routing outputs carry the combinational result or the flip-flop. A third output always carries the flip-flop, for the register chain.

Top module: `lcell_row`

## Requirements
- R1: In general-logic mode (mode bit 0), a cell's result equals truth-table bit number {d,c,b,a}, where input d is the most significant index bit.
- R2: In arithmetic mode (mode bit 1), the result is table bit 8+{a,b,cin} and the cell's carry is table bit {a,b,cin}, with a as the most significant index bit. The table 16'h96E8 therefore makes a full adder.
- R3: The carry input of cell i is the carry of cell i-1. Cell 0 takes `carry_in`, and the carry of the top cell appears on `carry_out`.
- R4: A cell in general-logic mode drives its carry to 0.
- R5: When a cell's output-select bit is 1, its routing outputs show its flip-flop. When the bit is 0, they show its combinational result, without waiting for a clock edge.
- R6: For every cell, the local and long-route outputs always carry the same value.
- R7: Asserting `grp_aclr` clears every flip-flop at once, without a clock edge. It overrides every other control.
- R8: A clock edge with `grp_sclr` high clears every flip-flop. This takes priority over load and capture.
- R9: A clock edge with `grp_sload` high and `grp_sclr` low loads `ld_data[i]` into the flip-flop of cell i.
- R10: With both synchronous controls low, a cell whose chain-select bit is 1 captures the flip-flop of cell i-1. Cell 0 captures `chain_in`.
- R11: With both synchronous controls low and chain-select 0, the flip-flop captures the cell's table result. In arithmetic mode this is the sum bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Row clock |
| grp_aclr | input | 1 | Asynchronous clear of all flip-flops, active high |
| grp_sclr | input | 1 | Synchronous clear of all flip-flops |
| grp_sload | input | 1 | Synchronous load from ld_data |
| cfg_lut | input | CELLS x 16 | Truth table of each cell |
| cfg_arith | input | CELLS | Mode bit per cell, 1 for arithmetic |
| cfg_regout | input | CELLS | Output-select bit per cell, 1 for the flip-flop |
| cfg_chain | input | CELLS | Flip-flop input select per cell, 1 for the register chain |
| in_a | input | CELLS | Data input a of each cell |
| in_b | input | CELLS | Data input b of each cell |
| in_c | input | CELLS | Data input c of each cell |
| in_d | input | CELLS | Data input d of each cell |
| ld_data | input | CELLS | Synchronous load value per cell |
| carry_in | input | 1 | Carry into cell 0 |
| chain_in | input | 1 | Register-chain input of cell 0 |
| out_local | output | CELLS | Local routing output per cell |
| out_route | output | CELLS | Long-route output per cell |
| out_chain | output | CELLS | Flip-flop value per cell, for the register chain |
| carry_out | output | 1 | Carry from the top cell |

## Verification
Each cell holds a single bit of state, and that bit reaches `out_chain` at once. A wrongly cleared, loaded or shifted flip-flop is therefore visible on the first sample after the offending edge. It also appears on the routing outputs of any cell whose output-select bit is set. An error in the carry path or the table index gives no stored state away. It shows up combinationally as a wrong sum pattern or a wrong `carry_out` for particular operand pairs. For this reason the adder vectors include long carry ripples and all-ones operands.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

    localparam int LUT_K  = 4;
    localparam int TBL_W  = 1 << LUT_K;
    localparam int HALF_W = TBL_W / 2;

    typedef struct packed {
        logic [TBL_W-1:0] tbl;
        logic             arith;
        logic             reg_out;
        logic             chain_sel;
    } cell_cfg_t;

    typedef struct packed {
        logic q;
    } cell_state_t;

endpackage

// File: rtl/lcell_lut.sv
module lcell_lut
    import lcell_pkg::*;
(
    input  logic [TBL_W-1:0] tbl,
    input  logic             arith,
    input  logic             in_a,
    input  logic             in_b,
    input  logic             in_c,
    input  logic             in_d,
    input  logic             cin,
    output logic             result,
    output logic             cout
);

    logic [LUT_K-1:0]  idx_full;
    logic [LUT_K-2:0]  idx_half;
    logic [HALF_W-1:0] tbl_sum;
    logic [HALF_W-1:0] tbl_cy;

    always_comb begin
        idx_full = {in_d, in_c, in_b, in_a};
        idx_half = {in_a, in_b, cin};
        tbl_sum  = tbl[TBL_W-1:HALF_W];
        tbl_cy   = tbl[HALF_W-1:0];
        if (arith) begin
            result = tbl_sum[idx_half];
            cout   = tbl_cy[idx_half];
        end else begin
            result = tbl[idx_full];
            cout   = 1'b0;
        end
    end

endmodule

// File: rtl/lcell_reg.sv
module lcell_reg
    import lcell_pkg::*;
(
    input  logic clk,
    input  logic aclr,
    input  logic sclr,
    input  logic sload,
    input  logic ld_bit,
    input  logic chain_sel,
    input  logic chain_bit,
    input  logic lut_bit,
    output logic q
);

    cell_state_t state_d;
    cell_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (sclr) begin
            state_d.q = 1'b0;
        end else if (sload) begin
            state_d.q = ld_bit;
        end else if (chain_sel) begin
            state_d.q = chain_bit;
        end else begin
            state_d.q = lut_bit;
        end
    end

    always_ff @(posedge clk or posedge aclr) begin
        if (aclr) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q = state_q.q;

endmodule

// File: rtl/lcell.sv
module lcell
    import lcell_pkg::*;
(
    input  logic       clk,
    input  logic       aclr,
    input  logic       sclr,
    input  logic       sload,
    input  cell_cfg_t  cfg,
    input  logic       in_a,
    input  logic       in_b,
    input  logic       in_c,
    input  logic       in_d,
    input  logic       ld_bit,
    input  logic       cin,
    input  logic       chain_bit,
    output logic       out_local,
    output logic       out_route,
    output logic       out_chain,
    output logic       cout
);

    logic lut_res;
    logic ff_q;
    logic sel_out;

    lcell_lut i_lut (
        .tbl    (cfg.tbl),
        .arith  (cfg.arith),
        .in_a   (in_a),
        .in_b   (in_b),
        .in_c   (in_c),
        .in_d   (in_d),
        .cin    (cin),
        .result (lut_res),
        .cout   (cout)
    );

    lcell_reg i_reg (
        .clk       (clk),
        .aclr      (aclr),
        .sclr      (sclr),
        .sload     (sload),
        .ld_bit    (ld_bit),
        .chain_sel (cfg.chain_sel),
        .chain_bit (chain_bit),
        .lut_bit   (lut_res),
        .q         (ff_q)
    );

    always_comb begin
        sel_out = cfg.reg_out ? ff_q : lut_res;
    end

    assign out_local = sel_out;
    assign out_route = sel_out;
    assign out_chain = ff_q;

endmodule

// File: rtl/lcell_row.sv
module lcell_row
    import lcell_pkg::*;
#(
    parameter int CELLS = 8
) (
    input  logic                         clk,
    input  logic                         grp_aclr,
    input  logic                         grp_sclr,
    input  logic                         grp_sload,
    input  logic [CELLS-1:0][TBL_W-1:0]  cfg_lut,
    input  logic [CELLS-1:0]             cfg_arith,
    input  logic [CELLS-1:0]             cfg_regout,
    input  logic [CELLS-1:0]             cfg_chain,
    input  logic [CELLS-1:0]             in_a,
    input  logic [CELLS-1:0]             in_b,
    input  logic [CELLS-1:0]             in_c,
    input  logic [CELLS-1:0]             in_d,
    input  logic [CELLS-1:0]             ld_data,
    input  logic                         carry_in,
    input  logic                         chain_in,
    output logic [CELLS-1:0]             out_local,
    output logic [CELLS-1:0]             out_route,
    output logic [CELLS-1:0]             out_chain,
    output logic                         carry_out
);

    localparam int LINKS = CELLS + 1;

    logic [LINKS-1:0] carry_link;
    logic [LINKS-1:0] reg_link;

    assign carry_link[0] = carry_in;
    assign reg_link[0]   = chain_in;

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        cell_cfg_t cfg_i;

        always_comb begin
            cfg_i.tbl       = cfg_lut[i];
            cfg_i.arith     = cfg_arith[i];
            cfg_i.reg_out   = cfg_regout[i];
            cfg_i.chain_sel = cfg_chain[i];
        end

        lcell i_cell (
            .clk       (clk),
            .aclr      (grp_aclr),
            .sclr      (grp_sclr),
            .sload     (grp_sload),
            .cfg       (cfg_i),
            .in_a      (in_a[i]),
            .in_b      (in_b[i]),
            .in_c      (in_c[i]),
            .in_d      (in_d[i]),
            .ld_bit    (ld_data[i]),
            .cin       (carry_link[i]),
            .chain_bit (reg_link[i]),
            .out_local (out_local[i]),
            .out_route (out_route[i]),
            .out_chain (reg_link[i+1]),
            .cout      (carry_link[i+1])
        );
    end

    assign out_chain = reg_link[CELLS:1];
    assign carry_out = carry_link[CELLS];

endmodule

// File: rtl/lcell_row_chk.sv
module lcell_row_chk #(
    parameter int CELLS = 8
) (
    input logic             clk,
    input logic             grp_aclr,
    input logic             grp_sclr,
    input logic             grp_sload,
    input logic             last_arith,
    input logic [CELLS-1:0] cfg_regout,
    input logic [CELLS-1:0] cfg_chain,
    input logic [CELLS-1:0] ld_data,
    input logic             chain_in,
    input logic [CELLS-1:0] out_local,
    input logic [CELLS-1:0] out_chain,
    input logic             carry_out
);

    logic [CELLS-1:0] prev_q;
    assign prev_q = {out_chain[CELLS-2:0], chain_in};

    AST_NORMAL_NO_CARRY: assert property (@(posedge clk) disable iff (grp_aclr)
        !last_arith |-> (carry_out == 1'b0)); // R4

    AST_REGOUT_SHOWS_FF: assert property (@(posedge clk) disable iff (grp_aclr)
        ((out_local ^ out_chain) & cfg_regout) == '0); // R5

    AST_ACLR_CLEARS: assert property (@(posedge clk)
        grp_aclr |-> (out_chain == '0)); // R7

    AST_SCLR_CLEARS: assert property (@(posedge clk) disable iff (grp_aclr)
        grp_sclr |=> (out_chain == '0)); // R8

    AST_SLOAD_LOADS: assert property (@(posedge clk) disable iff (grp_aclr)
        (grp_sload && !grp_sclr) |=> (out_chain == $past(ld_data))); // R9

    AST_CHAIN_SHIFTS: assert property (@(posedge clk) disable iff (grp_aclr)
        (!grp_sload && !grp_sclr) |=>
            (((out_chain ^ $past(prev_q)) & $past(cfg_chain)) == '0)); // R10

endmodule

bind lcell_row lcell_row_chk #(.CELLS(CELLS)) i_chk (
    .clk        (clk),
    .grp_aclr   (grp_aclr),
    .grp_sclr   (grp_sclr),
    .grp_sload  (grp_sload),
    .last_arith (cfg_arith[CELLS-1]),
    .cfg_regout (cfg_regout),
    .cfg_chain  (cfg_chain),
    .ld_data    (ld_data),
    .chain_in   (chain_in),
    .out_local  (out_local),
    .out_chain  (out_chain),
    .carry_out  (carry_out)
);

// File: tb/test_lcell_row.sv
`timescale 1ns/1ps
module test_lcell_row;

    localparam int CELLS = 8;
    localparam logic [15:0] FA_TBL = 16'h96E8;
    localparam logic [15:0] GEN_TBL = 16'h6B29;
    localparam int NVEC = 12;
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 8'h00, 8'h00}, {1'b1, 8'h00, 8'h00}, {1'b0, 8'hFF, 8'h01},
        {1'b1, 8'hFF, 8'hFF}, {1'b0, 8'h7F, 8'h01}, {1'b0, 8'h55, 8'hAA},
        {1'b1, 8'h55, 8'hAA}, {1'b0, 8'h3C, 8'hC3}, {1'b1, 8'h12, 8'h34},
        {1'b0, 8'h80, 8'h80}, {1'b0, 8'hA7, 8'h6E}, {1'b1, 8'h0F, 8'hF0}
    };

    logic                     clk = 1'b0;
    logic                     grp_aclr = 1'b1;
    logic                     grp_sclr = 1'b0;
    logic                     grp_sload = 1'b0;
    logic [CELLS-1:0][15:0]   cfg_lut = '0;
    logic [CELLS-1:0]         cfg_arith = '0;
    logic [CELLS-1:0]         cfg_regout = '1;
    logic [CELLS-1:0]         cfg_chain = '0;
    logic [CELLS-1:0]         in_a = '0, in_b = '0, in_c = '0, in_d = '0;
    logic [CELLS-1:0]         ld_data = '0;
    logic                     carry_in = 1'b0;
    logic                     chain_in = 1'b0;
    logic [CELLS-1:0]         out_local, out_route, out_chain;
    logic                     carry_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lcell_row #(.CELLS(CELLS)) i_lcell_row (
        .clk(clk), .grp_aclr(grp_aclr), .grp_sclr(grp_sclr), .grp_sload(grp_sload),
        .cfg_lut(cfg_lut), .cfg_arith(cfg_arith), .cfg_regout(cfg_regout),
        .cfg_chain(cfg_chain), .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
        .ld_data(ld_data), .carry_in(carry_in), .chain_in(chain_in),
        .out_local(out_local), .out_route(out_route), .out_chain(out_chain),
        .carry_out(carry_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [8:0] exp_sum;
        #1;
        check("R7 reset flip-flops", out_chain, 8'h00);
        check("R5 reset outputs", out_local, 8'h00);
        @(negedge clk);
        grp_aclr = 1'b0;

        // R2 R3: ripple adder vectors, combinational outputs
        cfg_lut = {CELLS{FA_TBL}};
        cfg_arith = '1;
        cfg_regout = '0;
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            carry_in = VEC[i][16];
            in_a = VEC[i][15:8];
            in_b = VEC[i][7:0];
            #1;
            exp_sum = {1'b0, VEC[i][15:8]} + {1'b0, VEC[i][7:0]} + {8'h00, VEC[i][16]};
            check("R2 R3 adder", {carry_out, out_local}, exp_sum);
            check("R6 route copy", out_route, out_local);
        end

        // R1 R4: general-logic mode over all 16 indices
        cfg_lut = {CELLS{GEN_TBL}};
        cfg_arith = '0;
        carry_in = 1'b1;
        for (int idx = 0; idx < 16; idx++) begin
            @(negedge clk);
            in_a = {CELLS{idx[0]}};
            in_b = {CELLS{idx[1]}};
            in_c = {CELLS{idx[2]}};
            in_d = {CELLS{idx[3]}};
            #1;
            check("R1 table lookup", out_local, {CELLS{GEN_TBL[idx]}});
            check("R4 no carry", carry_out, 1'b0);
        end

        // R11 R5: registered sum capture
        cfg_lut = {CELLS{FA_TBL}};
        cfg_arith = '1;
        cfg_regout = '1;
        @(negedge clk);
        carry_in = 1'b0; in_a = 8'h3C; in_b = 8'h0F;
        @(negedge clk);
        check("R11 sum captured", out_chain, 8'h4B);
        in_a = 8'h01; in_b = 8'h01;
        #1;
        check("R5 registered hold", out_local, 8'h4B);
        cfg_regout = '0;
        #1;
        check("R5 combinational select", out_local, 8'h02);
        cfg_regout = '1;

        // R9: synchronous load
        @(negedge clk);
        ld_data = 8'h5A; grp_sload = 1'b1;
        @(negedge clk);
        check("R9 load", out_chain, 8'h5A);
        check("R6 route registered", out_route, 8'h5A);

        // R8: clear beats load
        grp_sclr = 1'b1;
        @(negedge clk);
        check("R8 clear priority", out_chain, 8'h00);
        grp_sclr = 1'b0;

        // R10: register chain shift
        @(negedge clk);
        check("R9 reload", out_chain, 8'h5A);
        grp_sload = 1'b0; cfg_chain = '1; chain_in = 1'b1;
        @(negedge clk);
        check("R10 shift in one", out_chain, 8'hB5);
        chain_in = 1'b0;
        @(negedge clk);
        check("R10 shift in zero", out_chain, 8'h6A);

        // R7: asynchronous clear, mid-cycle, overrides load
        ld_data = 8'hFF; grp_sload = 1'b1;
        @(negedge clk);
        check("R9 load ones", out_chain, 8'hFF);
        #1;
        grp_aclr = 1'b1;
        #0.5;
        check("R7 async clear", out_chain, 8'h00);
        @(negedge clk);
        check("R7 clear holds over load", out_chain, 8'h00);
        grp_aclr = 1'b0; grp_sload = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule